// File: doc/BRIEF.md
# Switch Input Port with Per-Output Queues

This block is the receive side of one port of an on-chip packet switch. Flits arrive over a valid/ready link. Each accepted flit is parked in a single staging register. While it sits there, the block presents the flit's destination field to an external route unit and waits for an answer. The answer names the output the flit must leave through and gives the rewritten destination field. The block splices the new field into the flit and writes the result into the queue that belongs to that output.

There is one FIFO for every output of the switch, so a flit waiting for a busy output cannot hold up traffic bound for an idle one. Each queue shows its oldest flit and a valid flag to the crossbar, which removes flits with one pop line per queue. The header is rewritten before the flit is queued, so nothing past the crossbar has to store or change a flit. If the chosen queue is full, the staged flit stays where it is and the link stalls. Later flits are not allowed to pass it, so link order is kept.

Top module: `voq_input_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1, `rt_req_valid` is 0 and every bit of `q_valid` is 0.
- R2: The cycle after a flit is accepted (`in_valid` and `in_ready` both 1), `rt_req_valid` is 1 and `rt_req_hdr` equals bits [31:24] of that flit. Both stay unchanged until a cycle in which `rt_rsp_valid` is 1.
- R3: `rt_rsp_valid` is acted on only in a cycle where `rt_req_valid` is 1. In any other cycle the response inputs have no effect on queue contents or on `in_ready`.
- R4: A queued flit equals the accepted flit with bits [31:24] replaced by `rt_rsp_hdr` from the accepted response. Bits [23:0] are unchanged.
- R5: The flit goes to the queue indexed by `rt_rsp_port`. A port value equal to the port's own input direction (`SELF_PORT`, when that differs from `LOCAL_PORT`) is sent to queue `LOCAL_PORT`, and so is any value of `NUM_OUT` or above. At most one queue is written per cycle.
- R6: If the target queue is not full, the flit is written in the same cycle the response is accepted, and it is visible at that queue's head output one cycle later if the queue was empty. If the queue is full, the route result is held and the flit is written in the first cycle the queue has room.
- R7: `in_ready` is 1 exactly when the staging register is empty, or when it is being written into a queue in that same cycle.
- R8: Each queue hands out flits in the order they were written. `q_valid[i]` is 1 when queue i holds a flit, and `q_data` slice i carries the oldest one. `q_pop[i]` removes that flit, and pops on several queues in one cycle all take effect. A pop on an empty queue is ignored.
- R9: A queue holds at most `DEPTH` flits and is never written while full. The count checked is the one before that cycle's pop. A flit blocked on a full queue also holds back every later flit on the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Port can take a flit this cycle |
| in_flit | input | FLIT_W | Incoming flit |
| rt_req_valid | output | 1 | Staged flit awaits a route decision |
| rt_req_hdr | output | HDR_W | Destination field of the staged flit |
| rt_rsp_valid | input | 1 | Route unit answer valid |
| rt_rsp_port | input | clog2(NUM_OUT) | Chosen output index |
| rt_rsp_hdr | input | HDR_W | Rewritten destination field |
| q_valid | output | NUM_OUT | Per-queue non-empty flags |
| q_data | output | NUM_OUT*FLIT_W | Per-queue head flits, queue i in slice i |
| q_pop | input | NUM_OUT | Per-queue remove-head strobes |

## Verification
The bench builds the port with five outputs, a depth of five, own direction 1 and local port 4. With a 3-bit port field, route answers can name the own direction and the out-of-range codes 5 to 7, so both redirect cases get exercised. Spurious responses are driven while no request is pending. Phases with few pops fill the queues to capacity, which reaches full-queue stalls, the held route result and blocking of later flits on the link. Phases with many pops cover same-cycle push and pop, pops on empty queues, and simultaneous pops across queues.

// File: rtl/voq_pkg.sv
// Package: shared helpers for the per-output-queue input port.
// Assumes: callers pass positive counts.
package voq_pkg;

    // Index width for a count of n items, at least one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/voq_fifo.sv
// Module: voq_fifo
// Circular-buffer FIFO of DEPTH entries with head look-ahead. The head is
// valid whenever the FIFO is not empty.
// Assumes: push is only raised when full is low. A pop on an empty FIFO is dropped.
module voq_fifo
    import voq_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    localparam int AW = idx_w(DEPTH);
    localparam int CW = idx_w(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    // Qualify requests against the current occupancy.
    always_comb begin
        do_pop  = pop && (count != '0);
        do_push = push && (count != CAP);
    end

    // Storage write; entries need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping with explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Head and flags.
    always_comb begin
        head      = mem[rd_ptr];
        not_empty = (count != '0);
        full      = (count == CAP);
    end

endmodule

// File: rtl/voq_stage.sv
// Module: voq_stage
// One-flit staging register plus the route handshake. A freshly accepted
// flit raises a route request. The answer is either used at once (a drain
// into the target queue) or latched with the rewritten header until the
// queue has room. The drain target is one-hot.
// Assumes: the route unit keeps its answer meaningful only while the request is up.
module voq_stage
    import voq_pkg::*;
#(
    parameter int FLIT_W     = 32,
    parameter int HDR_W      = 8,
    parameter int HDR_LSB    = 24,
    parameter int NUM_OUT    = 5,
    parameter int SELF_PORT  = 1,
    parameter int LOCAL_PORT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [FLIT_W-1:0]           in_flit,
    output logic                        in_ready,
    output logic                        rt_req_valid,
    output logic [HDR_W-1:0]            rt_req_hdr,
    input  logic                        rt_rsp_valid,
    input  logic [idx_w(NUM_OUT)-1:0]   rt_rsp_port,
    input  logic [HDR_W-1:0]            rt_rsp_hdr,
    input  logic [NUM_OUT-1:0]          q_full,
    output logic [NUM_OUT-1:0]          push_en,
    output logic [FLIT_W-1:0]           push_data
);
    localparam int PW = idx_w(NUM_OUT);
    localparam logic [PW-1:0] LOCAL_IDX = PW'(LOCAL_PORT);
    localparam logic [PW-1:0] SELF_IDX  = PW'(SELF_PORT);
    localparam bit            TURN_BACK = (SELF_PORT != LOCAL_PORT);

    logic              st_full;
    logic              st_routed;
    logic [PW-1:0]     st_port;
    logic [FLIT_W-1:0] st_flit;

    logic              rsp_take;
    logic [PW-1:0]     rsp_port_m;
    logic [FLIT_W-1:0] rsp_flit;
    logic [PW-1:0]     tgt_port;
    logic [FLIT_W-1:0] tgt_flit;
    logic              drain;

    // Map the raw answer: out-of-range or back toward the own direction goes local.
    always_comb begin
        rsp_port_m = rt_rsp_port;
        if (int'(rt_rsp_port) >= NUM_OUT)         rsp_port_m = LOCAL_IDX;
        else if (TURN_BACK && rt_rsp_port == SELF_IDX) rsp_port_m = LOCAL_IDX;
    end

    // Splice the new destination field into the staged flit.
    always_comb begin
        rsp_flit = st_flit;
        rsp_flit[HDR_LSB +: HDR_W] = rt_rsp_hdr;
    end

    // Request handshake and drain decision.
    always_comb begin
        rt_req_valid = st_full && !st_routed;
        rt_req_hdr   = st_flit[HDR_LSB +: HDR_W];
        rsp_take     = rt_req_valid && rt_rsp_valid;
        tgt_port     = st_routed ? st_port : rsp_port_m;
        tgt_flit     = st_routed ? st_flit : rsp_flit;
        drain        = (st_routed || rsp_take) && !q_full[tgt_port];
        in_ready     = !st_full || drain;
    end

    // One-hot write strobe toward the queue array.
    always_comb begin
        push_en   = '0;
        push_data = tgt_flit;
        if (drain) push_en[tgt_port] = 1'b1;
    end

    // Staging register: load, drain, or latch a route that cannot drain yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_full   <= 1'b0;
            st_routed <= 1'b0;
            st_port   <= '0;
            st_flit   <= '0;
        end else if (in_valid && in_ready) begin
            st_full   <= 1'b1;
            st_routed <= 1'b0;
            st_flit   <= in_flit;
        end else if (drain) begin
            st_full   <= 1'b0;
            st_routed <= 1'b0;
        end else if (rsp_take) begin
            st_routed <= 1'b1;
            st_port   <= rsp_port_m;
            st_flit   <= rsp_flit;
        end
    end

endmodule

// File: rtl/voq_input_port.sv
// Module: voq_input_port (top)
// Input side of one switch port: a staging register with a route handshake
// that feeds NUM_OUT parallel FIFOs, one per switch output. Each FIFO offers
// its head to the crossbar and takes its own pop strobe.
// Assumes: the header field sits at [HDR_LSB +: HDR_W] of every flit.
module voq_input_port
    import voq_pkg::*;
#(
    parameter int FLIT_W     = 32,
    parameter int HDR_W      = 8,
    parameter int HDR_LSB    = FLIT_W - HDR_W,
    parameter int NUM_OUT    = 5,
    parameter int DEPTH      = 5,
    parameter int SELF_PORT  = 1,
    parameter int LOCAL_PORT = NUM_OUT - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [FLIT_W-1:0]           in_flit,
    output logic                        rt_req_valid,
    output logic [HDR_W-1:0]            rt_req_hdr,
    input  logic                        rt_rsp_valid,
    input  logic [idx_w(NUM_OUT)-1:0]   rt_rsp_port,
    input  logic [HDR_W-1:0]            rt_rsp_hdr,
    output logic [NUM_OUT-1:0]          q_valid,
    output logic [NUM_OUT*FLIT_W-1:0]   q_data,
    input  logic [NUM_OUT-1:0]          q_pop
);
    logic [NUM_OUT-1:0] push_en;
    logic [NUM_OUT-1:0] q_full;
    logic [FLIT_W-1:0]  push_data;

    voq_stage #(
        .FLIT_W(FLIT_W), .HDR_W(HDR_W), .HDR_LSB(HDR_LSB),
        .NUM_OUT(NUM_OUT), .SELF_PORT(SELF_PORT), .LOCAL_PORT(LOCAL_PORT)
    ) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .rt_req_valid(rt_req_valid), .rt_req_hdr(rt_req_hdr),
        .rt_rsp_valid(rt_rsp_valid), .rt_rsp_port(rt_rsp_port),
        .rt_rsp_hdr(rt_rsp_hdr),
        .q_full(q_full), .push_en(push_en), .push_data(push_data)
    );

    // One FIFO per switch output.
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_queue
        voq_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push_en[g]), .push_data(push_data),
            .pop(q_pop[g]),
            .head(q_data[g*FLIT_W +: FLIT_W]),
            .not_empty(q_valid[g]),
            .full(q_full[g])
        );
    end

endmodule

// File: rtl/voq_input_port_chk.sv
// Module: voq_input_port_chk
// Protocol and structural checks for voq_input_port, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module voq_input_port_chk #(
    parameter int NUM_OUT    = 5,
    parameter int HDR_W      = 8,
    parameter int SELF_PORT  = 1,
    parameter int LOCAL_PORT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               rt_req_valid,
    input logic [HDR_W-1:0]   rt_req_hdr,
    input logic               rt_rsp_valid,
    input logic [NUM_OUT-1:0] q_valid,
    input logic [NUM_OUT-1:0] q_pop,
    input logic [NUM_OUT-1:0] push_en,
    input logic [NUM_OUT-1:0] q_full
);
    // R2
    accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> rt_req_valid);

    // R2
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_req_valid && !rt_rsp_valid |=> rt_req_valid && $stable(rt_req_hdr));

    // R7
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_req_valid && !rt_rsp_valid |-> !in_ready);

    // R5
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_en));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en & q_full) == '0);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_keep
        // R8
        head_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q_valid[g] && !q_pop[g] |=> q_valid[g]);
    end

    if (SELF_PORT != LOCAL_PORT && SELF_PORT < NUM_OUT) begin : g_self
        // R5
        no_turn_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !push_en[SELF_PORT]);
    end

endmodule

bind voq_input_port voq_input_port_chk #(
    .NUM_OUT(NUM_OUT), .HDR_W(HDR_W),
    .SELF_PORT(SELF_PORT), .LOCAL_PORT(LOCAL_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .rt_req_valid(rt_req_valid), .rt_req_hdr(rt_req_hdr),
    .rt_rsp_valid(rt_rsp_valid),
    .q_valid(q_valid), .q_pop(q_pop),
    .push_en(push_en), .q_full(q_full)
);

// File: tb/voq_input_port_bench.sv
// Bench: behavioural reference model (SV queues) compared every cycle.
module voq_input_port_bench;
    localparam int NQ    = 5;
    localparam int DEP   = 5;
    localparam int SELFP = 1;
    localparam int LOCP  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_flit = '0;
    logic        rt_req_valid;
    logic [7:0]  rt_req_hdr;
    logic        rt_rsp_valid = 1'b0;
    logic [2:0]  rt_rsp_port = '0;
    logic [7:0]  rt_rsp_hdr = '0;
    logic [NQ-1:0]    q_valid;
    logic [NQ*32-1:0] q_data;
    logic [NQ-1:0]    q_pop = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    voq_input_port #(
        .FLIT_W(32), .HDR_W(8), .NUM_OUT(NQ), .DEPTH(DEP),
        .SELF_PORT(SELFP), .LOCAL_PORT(LOCP)
    ) u_voq_input_port (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .rt_req_valid(rt_req_valid), .rt_req_hdr(rt_req_hdr),
        .rt_rsp_valid(rt_rsp_valid), .rt_rsp_port(rt_rsp_port),
        .rt_rsp_hdr(rt_rsp_hdr),
        .q_valid(q_valid), .q_data(q_data), .q_pop(q_pop)
    );

    // Reference state.
    bit          m_full, m_res;
    int          m_port;
    logic [31:0] m_flit;
    logic [31:0] mq [NQ][$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int map_port(input int p);
        if (p >= NQ) return LOCP;
        if (p == SELFP && SELFP != LOCP) return LOCP;
        return p;
    endfunction

    // One cycle: drive, compare after settling, advance the model.
    task automatic cycle(input int pv, input int pr, input int pp);
        int          tgt;
        logic [31:0] wflit;
        bit          take, can, rdy;
        @(negedge clk);
        in_valid     = ($urandom_range(99) < pv);
        in_flit      = $urandom;
        rt_rsp_valid = ($urandom_range(99) < pr);
        rt_rsp_port  = 3'($urandom_range(7));
        rt_rsp_hdr   = 8'($urandom);
        for (int i = 0; i < NQ; i++) q_pop[i] = ($urandom_range(99) < pp);
        #1;
        // R3: the answer counts only while a request is up.
        take = m_full && !m_res && rt_rsp_valid;
        if (m_res) begin
            tgt = m_port; wflit = m_flit;
        end else begin
            tgt = map_port(int'(rt_rsp_port)); wflit = m_flit; wflit[31:24] = rt_rsp_hdr;
        end
        // R6 and R9: drain only with room, counted before this cycle's pop.
        can = m_full && (m_res || take) && (mq[tgt].size() < DEP);
        rdy = !m_full || can;
        check("R7/R9 in_ready", 32'(in_ready), 32'(rdy));
        check("R2/R3/R6 rt_req_valid", 32'(rt_req_valid), 32'(m_full && !m_res));
        if (m_full && !m_res) check("R2 rt_req_hdr", 32'(rt_req_hdr), 32'(m_flit[31:24]));
        for (int i = 0; i < NQ; i++) begin
            check("R8 q_valid", 32'(q_valid[i]), 32'(mq[i].size() > 0));
            if (mq[i].size() > 0) check("R4/R5/R8 q_data", q_data[i*32 +: 32], mq[i][0]);
        end
        for (int i = 0; i < NQ; i++)
            if (q_pop[i] && mq[i].size() > 0) void'(mq[i].pop_front());
        if (can) mq[tgt].push_back(wflit);
        if (in_valid && rdy) begin
            m_full = 1; m_res = 0; m_flit = in_flit;
        end else if (can) begin
            m_full = 0; m_res = 0;
        end else if (take) begin
            m_res = 1; m_port = tgt; m_flit = wflit;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values while held.
        check("R1 in_ready", 32'(in_ready), 32'd1);
        check("R1 rt_req_valid", 32'(rt_req_valid), 32'd0);
        check("R1 q_valid", 32'(q_valid), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 in_ready after", 32'(in_ready), 32'd1);
        check("R1 q_valid after", 32'(q_valid), 32'd0);
        m_full = 0; m_res = 0; m_port = 0; m_flit = '0;
        for (int n = 0; n < 3000; n++) cycle(70, 50, 50);
        for (int n = 0; n < 2000; n++) cycle(80, 60, 5);
        for (int n = 0; n < 2000; n++) cycle(60, 40, 90);
        for (int n = 0; n < 2000; n++) cycle(90, 90, 30);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1500000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule